// File: doc/BRIEF.md
# Power-Up Recall and Ready Sequencer

This block brings a converter channel out of power-up in a safe order. When the digital supply-good flag rises, the block synchronises it and fires a one-cycle load strobe. The strobe copies the stored initial converter code and the stored configuration byte into their volatile registers. The strobe also clears the volatile nonvolatile-write mode bit. The block then counts a programmed number of clock cycles before it drives its active-low ready output low. The ready output rises again in the same cycle that the synchronised supply flag falls. A fall of the supply during the delay restarts the whole sequence.

While the channel is not ready, the block blocks three inputs: the asynchronous clear, the serial-port sampling enable and the up/down stepping enable. It also holds the buffered-output enable low whatever the output-enable pin does. Once the channel is ready, the synchronised output-enable pin controls the buffer directly.

Top module: `pwrup_recall_seq`

## Requirements
- R1: While reset is held, rdy_n_o is 1 and recall_stb_o, buf_en_o, clr_o, ser_en_o and step_en_o are all 0.
- R2: Each time the synchronised supply flag rises, recall_stb_o is high for exactly one cycle. The pulse comes in the cycle that follows the first edge at which the synchronised flag is seen high.
- R3: With supply_ok_i held high, rdy_n_o goes low exactly SYNC_STAGES+2+DELAY_CYCLES rising clock edges after the input rises. This is always after the recall strobe.
- R4: After supply_ok_i falls, rdy_n_o returns to 1 after exactly SYNC_STAGES rising edges, with no further delay.
- R5: A supply drop of at least one synchronised cycle during the delay restarts it. Ready then asserts the full R3 latency after supply_ok_i rises again.
- R6: buf_en_o is 0 whenever rdy_n_o is 1. When the channel is ready, buf_en_o equals oe_i delayed by SYNC_STAGES edges (OE_SYNC=1).
- R7: clr_o equals clr_i while ready and is 0 while rdy_n_o is 1.
- R8: ser_en_o is 1 only when ready and cs_n_i is 0.
- R9: step_en_o is 1 only when ready and cs_n_i is 1.
- R10: mode_clr_o is 1 from reset through the recall cycle. It is 0 during the delay and while ready, and it returns to 1 when the synchronised supply flag falls.
- R11: While recall_stb_o is high, dac_load_o equals stored_dac_i and cfg_load_o equals stored_cfg_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Digital supply-good flag, asynchronous |
| oe_i | input | 1 | Output-enable pin for the buffered output |
| clr_i | input | 1 | Asynchronous clear request |
| cs_n_i | input | 1 | Serial chip select, active low |
| stored_dac_i | input | DAC_W | Stored initial converter code |
| stored_cfg_i | input | CFG_W | Stored configuration byte |
| rdy_n_o | output | 1 | Ready, active low |
| recall_stb_o | output | 1 | One-cycle recall load strobe |
| dac_load_o | output | DAC_W | Code to load on the strobe |
| cfg_load_o | output | CFG_W | Configuration to load on the strobe |
| mode_clr_o | output | 1 | Holds the volatile write-mode bit cleared |
| buf_en_o | output | 1 | Buffered-output enable |
| clr_o | output | 1 | Gated clear |
| ser_en_o | output | 1 | Serial input sampling enable |
| step_en_o | output | 1 | Up/down stepping enable |

## Verification
The bench measures the exact edge count from a supply rise to ready. A counter that is off by one, or that starts at the strobe instead of at the end of recall, shows up as a wrong latency. The bench drops the supply in the middle of the delay. A counter that does not restart would then report ready too early. A drop after ready must raise rdy_n_o as soon as the synchronised flag falls, and a registered ready output would lag by one cycle. Random traffic on the output-enable, clear and chip-select pins checks that no gated output leaks while the channel is not ready.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   typedef enum logic [1:0] {
      SEQ_OFF    = 2'd0,
      SEQ_RECALL = 2'd1,
      SEQ_WAIT   = 2'd2,
      SEQ_READY  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwrseq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= '0;
            end else begin
               if (s == 0) begin
                  stage_q[s] <= d_i;
               end else begin
                  stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
               end
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
   parameter int DELAY_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

   generate
      if (DELAY_CYCLES < 1) begin : g_bad_delay
         $error("pwrseq_delay: DELAY_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
   import pwrseq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sup_ok_i,
   input  logic delay_done_i,
   output logic delay_run_o,
   output logic recall_o,
   output logic ready_o,
   output logic mode_clr_o
);
   seq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_OFF:    if (sup_ok_i) state_d = SEQ_RECALL;
         SEQ_RECALL: state_d = SEQ_WAIT;
         SEQ_WAIT:   if (delay_done_i) state_d = SEQ_READY;
         SEQ_READY:  state_d = SEQ_READY;
         default:    state_d = SEQ_OFF;
      endcase
      if (!sup_ok_i) state_d = SEQ_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_OFF;
      else        state_q <= state_d;
   end

   assign delay_run_o = (state_q == SEQ_WAIT) && sup_ok_i;
   assign recall_o    = (state_q == SEQ_RECALL) && sup_ok_i;
   assign ready_o     = (state_q == SEQ_READY) && sup_ok_i;
   assign mode_clr_o  = !(((state_q == SEQ_WAIT) || (state_q == SEQ_READY)) && sup_ok_i);
endmodule

// File: rtl/pwrseq_gate.sv
module pwrseq_gate (
   input  logic ready_i,
   input  logic oe_i,
   input  logic clr_i,
   input  logic cs_n_i,
   output logic buf_en_o,
   output logic clr_o,
   output logic ser_en_o,
   output logic step_en_o
);
   assign buf_en_o  = ready_i && oe_i;
   assign clr_o     = ready_i && clr_i;
   assign ser_en_o  = ready_i && !cs_n_i;
   assign step_en_o = ready_i && cs_n_i;
endmodule

// File: rtl/pwrup_recall_seq.sv
module pwrup_recall_seq #(
   parameter int DAC_W        = 12,
   parameter int CFG_W        = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int DELAY_CYCLES = 64,
   parameter bit OE_SYNC      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_ok_i,
   input  logic             oe_i,
   input  logic             clr_i,
   input  logic             cs_n_i,
   input  logic [DAC_W-1:0] stored_dac_i,
   input  logic [CFG_W-1:0] stored_cfg_i,
   output logic             rdy_n_o,
   output logic             recall_stb_o,
   output logic [DAC_W-1:0] dac_load_o,
   output logic [CFG_W-1:0] cfg_load_o,
   output logic             mode_clr_o,
   output logic             buf_en_o,
   output logic             clr_o,
   output logic             ser_en_o,
   output logic             step_en_o
);
   generate
      if (DAC_W < 1 || CFG_W < 1) begin : g_bad_width
         $error("pwrup_recall_seq: data widths must be positive");
      end
   endgenerate

   logic sup_s;
   logic oe_s;
   logic delay_run;
   logic delay_done;
   logic ready;

   pwrseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sup_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (supply_ok_i),
      .q_o   (sup_s)
   );

   generate
      if (OE_SYNC) begin : g_oe_sync
         pwrseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_oe_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (oe_i),
            .q_o   (oe_s)
         );
      end else begin : g_oe_direct
         assign oe_s = oe_i;
      end
   endgenerate

   pwrseq_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (delay_run),
      .done_o (delay_done)
   );

   pwrseq_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .sup_ok_i     (sup_s),
      .delay_done_i (delay_done),
      .delay_run_o  (delay_run),
      .recall_o     (recall_stb_o),
      .ready_o      (ready),
      .mode_clr_o   (mode_clr_o)
   );

   pwrseq_gate u_gate (
      .ready_i   (ready),
      .oe_i      (oe_s),
      .clr_i     (clr_i),
      .cs_n_i    (cs_n_i),
      .buf_en_o  (buf_en_o),
      .clr_o     (clr_o),
      .ser_en_o  (ser_en_o),
      .step_en_o (step_en_o)
   );

   assign rdy_n_o    = !ready;
   assign dac_load_o = stored_dac_i;
   assign cfg_load_o = stored_cfg_i;
endmodule

// File: rtl/pwrup_recall_seq_chk.sv
module pwrup_recall_seq_chk #(
   parameter int DELAY_CYCLES = 64
) (
   input logic clk,
   input logic rst_n,
   input logic sup_s,
   input logic rdy_n,
   input logic recall_stb,
   input logic buf_en,
   input logic clr_o,
   input logic ser_en,
   input logic step_en,
   input logic mode_clr
);
   localparam int WC_W = $clog2(DELAY_CYCLES + 3) + 1;
   localparam logic [WC_W-1:0] WC_MAX = {WC_W{1'b1}};

   logic [WC_W-1:0] wcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wcnt_q <= WC_MAX;
      else if (recall_stb)       wcnt_q <= WC_W'(1);
      else if (wcnt_q != WC_MAX) wcnt_q <= wcnt_q + 1'b1;
   end

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      recall_stb |=> !recall_stb); // R2
   AST_STB_BEFORE_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      recall_stb |-> rdy_n); // R3
   AST_DELAY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_n) |-> (wcnt_q == WC_W'(DELAY_CYCLES + 1))); // R3
   AST_DROP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sup_s) |-> rdy_n); // R4
   AST_BUF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_n |-> !buf_en); // R6
   AST_CLR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_n |-> !clr_o); // R7
   AST_SER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_n |-> !ser_en); // R8
   AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_n |-> !step_en); // R9
   AST_MODE_CLR_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_n |-> !mode_clr); // R10
   AST_MODE_CLR_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
      recall_stb |-> mode_clr); // R10
endmodule

bind pwrup_recall_seq pwrup_recall_seq_chk #(.DELAY_CYCLES(DELAY_CYCLES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sup_s      (sup_s),
   .rdy_n      (rdy_n_o),
   .recall_stb (recall_stb_o),
   .buf_en     (buf_en_o),
   .clr_o      (clr_o),
   .ser_en     (ser_en_o),
   .step_en    (step_en_o),
   .mode_clr   (mode_clr_o)
);

// File: tb/pwrup_recall_seq_tb_top.sv
`timescale 1ns/1ps
module pwrup_recall_seq_tb_top;
   localparam int DAC_W = 12;
   localparam int CFG_W = 8;
   localparam int S     = 2;
   localparam int D     = 64;
   localparam int LAT   = S + 2 + D;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b0, oe = 1'b0, clr = 1'b0, cs_n = 1'b1;
   logic [DAC_W-1:0] sdac = '0;
   logic [CFG_W-1:0] scfg = 8'h84;
   logic rdy_n, stb, mclr, buf_en, clr_g, ser_en, step_en;
   logic [DAC_W-1:0] dac_ld;
   logic [CFG_W-1:0] cfg_ld;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   int cyc    = 0;

   always #5 clk = ~clk;

   pwrup_recall_seq #(.DAC_W(DAC_W), .CFG_W(CFG_W), .SYNC_STAGES(S),
                      .DELAY_CYCLES(D), .OE_SYNC(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .oe_i(oe),
      .clr_i(clr), .cs_n_i(cs_n), .stored_dac_i(sdac), .stored_cfg_i(scfg),
      .rdy_n_o(rdy_n), .recall_stb_o(stb), .dac_load_o(dac_ld),
      .cfg_load_o(cfg_ld), .mode_clr_o(mclr), .buf_en_o(buf_en),
      .clr_o(clr_g), .ser_en_o(ser_en), .step_en_o(step_en));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Bench reference: supply and oe histories as seen through S sync stages
   logic [7:0] sup_h, oe_h;
   int run;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sup_h = '0; oe_h = '0; run = 0;
      end else begin
         sup_h = {sup_h[6:0], supply_ok};
         oe_h  = {oe_h[6:0], oe};
         if (sup_h[S-1]) run = (run < 1000000) ? run + 1 : run;
         else            run = 0;
      end
   end

   function automatic bit exp_ready();
      return sup_h[S-1] && (run >= D + 3);
   endfunction
   function automatic bit exp_stb();
      return sup_h[S-1] && (run == 2);
   endfunction
   function automatic bit exp_mclr();
      return !(sup_h[S-1] && (run >= 3));
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3/R4 rdy_n", rdy_n, !exp_ready());
         chk("R2 recall_stb", stb, exp_stb());
         chk("R10 mode_clr", mclr, exp_mclr());
         chk("R6 buf_en", buf_en, exp_ready() && oe_h[S-1]);
         chk("R7 clr_o", clr_g, exp_ready() && clr);
         chk("R8 ser_en", ser_en, exp_ready() && !cs_n);
         chk("R9 step_en", step_en, exp_ready() && cs_n);
         if (stb) begin
            chk("R11 dac_load", dac_ld, sdac);
            chk("R11 cfg_load", cfg_ld, scfg);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cyc);
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic drive(input logic s, input logic o, input logic c, input logic n);
      @(negedge clk); #1;
      supply_ok = s; oe = o; clr = c; cs_n = n;
   endtask

   task automatic measure_rise(input string tag);
      int k;
      k = 0;
      @(negedge clk); #1; supply_ok = 1'b1;
      for (int i = 0; i < LAT + 20; i++) begin
         @(negedge clk);
         k++;
         if (!rdy_n) break;
      end
      chk(tag, k, LAT);
   endtask

   initial begin
      int r;
      int d;
      r = $urandom(32'd2468);
      // R1: reset state with pins active
      oe = 1'b1; clr = 1'b1; cs_n = 1'b0; supply_ok = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 rdy_n", rdy_n, 1); chk("R1 stb", stb, 0); chk("R1 buf_en", buf_en, 0);
      chk("R1 clr_o", clr_g, 0); chk("R1 ser_en", ser_en, 0); chk("R1 step_en", step_en, 0);
      supply_ok = 1'b0; clr = 1'b0; cs_n = 1'b1;
      @(negedge clk); #1; rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R3: exact latency, with oe already high (R6 held off until ready)
      measure_rise("R3 latency");
      // R4: drop after ready
      begin
         int k;
         k = 0;
         #1; supply_ok = 1'b0;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            k++;
            if (rdy_n) break;
         end
         chk("R4 drop latency", k, S);
      end
      repeat (4) @(negedge clk);
      // R5: drop in the middle of the delay restarts it
      #1; supply_ok = 1'b1;
      repeat (S + 20) @(negedge clk);
      #1; supply_ok = 1'b0;
      repeat (2) @(negedge clk);
      measure_rise("R5 restart latency");
      // Random phase
      for (int i = 0; i < 6000; i++) begin
         sdac = DAC_W'($urandom);
         scfg = CFG_W'($urandom);
         if (supply_ok && ($urandom % 150) == 0) begin
            d = 1 + ($urandom % 6);
            for (int j = 0; j < d; j++) drive(1'b0, 1'($urandom), 1'($urandom), 1'($urandom));
         end else begin
            drive(1'b1, 1'($urandom), 1'($urandom), 1'($urandom));
         end
      end
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule